// File: doc/BRIEF.md
# Temperature Compensation Sequencing Controller

This block steers the temperature compensation of a crystal oscillator. It holds the compensation settings behind a simple register write/read port: an analog trim code, a digital trim byte, a curvature coefficient (alpha) and a control byte. The control byte carries a 4-bit beta field and the enable bits. While sensing is off, the oscillator trim outputs follow the loaded initial trim values. Once sensing is on, the block sends single-cycle conversion requests to an external sensor/ADC/correction engine. It then drives the oscillator with the corrected trim word that comes back with each completion pulse.

Requests are timed from a 1 Hz tick. On main power a request goes out every fast interval. On battery power, requests go out only when the battery-mode enable is set, and at either the fast or the slow interval chosen by a rate bit. A low-battery input forces the battery-mode enable off. The coefficient registers are write-locked while sensing runs. The block also decodes the active 6-bit analog trim code into a signed offset.

Top module: `tcomp_seq_ctrl`

Register map (3-bit address):
- 0 holds the analog trim, bits 5:0; bits 7:6 read 0.
- 1 holds the digital trim, bits 7:0.
- 2 holds alpha, bits 6:0; bit 7 reads 0.
- 3 is the control byte:
  - bit 7 is sensing enable.
  - bit 6 is battery-mode enable.
  - bit 5 is rate select.
  - bit 4 reads 0.
  - bits 3:0 are beta.
- Addresses 4 to 7 read 0.

## Requirements
- R1: After reset every register reads 0, conv_req is 0 and the oscillator outputs are 0.
- R2: While sensing enable (control bit 7) is 0, osc_atrim and osc_dtrim equal the analog and digital trim registers. After it rises they keep those values until a corrected word is accepted.
- R3: While sensing enable is 1, writes to addresses 0, 1 and 2 and to the beta field (control bits 3:0) are ignored. Control bits 7:5 stay writable.
- R4: The control byte reads back as {enable, battery enable, rate select, 0, beta}.
- R5: Alpha keeps bits 6:0 of the written byte and reads bit 7 as 0 (a coefficient of 0.034 scaled by 1024 is stored as 35). The analog trim reads bits 7:6 as 0, and unmapped addresses read 0.
- R6: The cycle after sensing enable goes 1 is seen, the tick count clears and a one-cycle conv_req is issued (if no request is outstanding and sensing is allowed in the current power mode).
- R7: On main power (on_battery = 0) with sensing enabled, a request is issued every CNT_FAST ticks (default 60), whatever the rate bit.
- R8: On battery, no request is issued unless the battery-mode enable is 1. When it is 1, the interval is CNT_SLOW ticks (default 600) with rate select 0 and CNT_FAST ticks with rate select 1.
- R9: While batt_low is 1 the battery-mode enable bit is cleared and cannot be written to 1.
- R10: Only one request is outstanding at a time. An interval that ends before conv_done returns is skipped.
- R11: A conv_done pulse that answers an outstanding request loads conv_atrim/conv_dtrim into the oscillator outputs if sensing is still enabled. If sensing was disabled before it arrived, the result is discarded.
- R12: atrim_offset is the two's-complement value 32 − code of the active analog trim code: 12 gives +20, 31 gives +1, 32 gives 0, 63 gives −31, 0 gives +32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| on_battery | input | 1 | 1 when running from the backup battery |
| batt_low | input | 1 | 1 when the battery is below its sensing threshold |
| conv_req | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_atrim | input | 6 | Corrected analog trim returned with conv_done |
| conv_dtrim | input | 8 | Corrected digital trim returned with conv_done |
| osc_atrim | output | 6 | Analog trim applied to the oscillator |
| osc_dtrim | output | 8 | Digital trim applied to the oscillator |
| atrim_offset | output | 7 | Signed decoded offset of osc_atrim |

## Verification
The scheduler is driven on main power with both rate settings, which shows that the rate bit has no effect there. It is also driven on battery with the battery enable clear, then set with the slow rate, then set with the fast rate, which separates the gating from the two interval lengths. The converter responder runs in three modes: it answers promptly, it stays silent across several intervals, and it answers after sensing has been turned off. These separate an accepted correction from a skipped period and from a discarded late result. Writes made while locked and writes made while batt_low is high are followed by readbacks, so that an ignored write shows at the port.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
  localparam int ATRIM_W = 6;
  localparam int DTRIM_W = 8;
  localparam int ALPHA_W = 7;
  localparam int BETA_W  = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int OFFS_W  = 7;

  localparam logic [ADDR_W-1:0] ADDR_ATRIM = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DTRIM = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ALPHA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd3;

  typedef struct packed {
    logic              sense_en;
    logic              bat_en;
    logic              rate_sel;
    logic              rsvd;
    logic [BETA_W-1:0] beta;
  } ctrl_t;

  // Upper half of the code space is the negative side, lower half positive.
  function automatic logic signed [OFFS_W-1:0] decode_atrim(input logic [ATRIM_W-1:0] code);
    int mag;
    int val;
    if (code[ATRIM_W-1]) begin
      mag = int'(code[ATRIM_W-2:0]);
      val = -mag;
    end else begin
      mag = int'(code);
      val = (1 << (ATRIM_W-1)) - mag;
    end
    return OFFS_W'(val);
  endfunction
endpackage

// File: rtl/tcomp_regfile.sv
module tcomp_regfile
  import tcomp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               batt_low,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [ATRIM_W-1:0] init_atrim,
  output logic [DTRIM_W-1:0] init_dtrim,
  output logic               sense_en,
  output logic               bat_en,
  output logic               rate_sel
);
  logic [ATRIM_W-1:0] atrim_q;
  logic [DTRIM_W-1:0] dtrim_q;
  logic [ALPHA_W-1:0] alpha_q;
  ctrl_t              ctrl_q;

  logic coef_locked;
  logic wr_atrim, wr_dtrim, wr_alpha, wr_ctrl;

  assign coef_locked = ctrl_q.sense_en;
  assign wr_atrim = reg_wr && (reg_addr == ADDR_ATRIM) && !coef_locked;
  assign wr_dtrim = reg_wr && (reg_addr == ADDR_DTRIM) && !coef_locked;
  assign wr_alpha = reg_wr && (reg_addr == ADDR_ALPHA) && !coef_locked;
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      atrim_q <= '0;
      dtrim_q <= '0;
      alpha_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_atrim) atrim_q <= reg_wdata[ATRIM_W-1:0];
      if (wr_dtrim) dtrim_q <= reg_wdata[DTRIM_W-1:0];
      if (wr_alpha) alpha_q <= reg_wdata[ALPHA_W-1:0];
      if (wr_ctrl) begin
        ctrl_q.sense_en <= reg_wdata[7];
        ctrl_q.bat_en   <= reg_wdata[6];
        ctrl_q.rate_sel <= reg_wdata[5];
        ctrl_q.rsvd     <= 1'b0;
        if (!coef_locked) ctrl_q.beta <= reg_wdata[BETA_W-1:0];
      end
      if (batt_low) ctrl_q.bat_en <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_ATRIM: reg_rdata = DATA_W'(atrim_q);
      ADDR_DTRIM: reg_rdata = DATA_W'(dtrim_q);
      ADDR_ALPHA: reg_rdata = DATA_W'(alpha_q);
      ADDR_CTRL:  reg_rdata = ctrl_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign init_atrim = atrim_q;
  assign init_dtrim = dtrim_q;
  assign sense_en   = ctrl_q.sense_en;
  assign bat_en     = ctrl_q.bat_en;
  assign rate_sel   = ctrl_q.rate_sel;

  // R3
  alpha_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_locked && reg_wr && reg_addr == ADDR_ALPHA) |=> $stable(alpha_q));
  // R3
  beta_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_locked && reg_wr && reg_addr == ADDR_CTRL) |=> $stable(ctrl_q.beta));
  // R9
  low_batt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_low |=> !ctrl_q.bat_en);
endmodule

// File: rtl/tcomp_scheduler.sv
module tcomp_scheduler #(
  parameter int CNT_FAST = 60,
  parameter int CNT_SLOW = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic sense_en,
  input  logic bat_en,
  input  logic rate_sel,
  input  logic on_battery,
  input  logic conv_done,
  output logic conv_req,
  output logic corr_load
);
  localparam int CNT_MAX = (CNT_SLOW > CNT_FAST) ? CNT_SLOW : CNT_FAST;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             en_d;
  logic             busy_q;

  logic en_rise, sense_active, period_hit, issue, done_accept;
  int   interval;

  assign en_rise      = sense_en && !en_d;
  assign sense_active = sense_en && (!on_battery || bat_en);
  assign interval     = (on_battery && !rate_sel) ? CNT_SLOW : CNT_FAST;
  assign period_hit   = sense_active && tick_1hz && (int'(tick_cnt) >= interval - 1);
  assign issue        = sense_active && !busy_q && (en_rise || period_hit);
  assign done_accept  = busy_q && conv_done;
  assign corr_load    = done_accept && sense_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      en_d     <= 1'b0;
      busy_q   <= 1'b0;
      conv_req <= 1'b0;
    end else begin
      en_d     <= sense_en;
      conv_req <= issue;
      if (en_rise || !sense_active)
        tick_cnt <= '0;
      else if (tick_1hz)
        tick_cnt <= period_hit ? '0 : tick_cnt + 1'b1;
      if (issue)
        busy_q <= 1'b1;
      else if (done_accept)
        busy_q <= 1'b0;
    end
  end

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_done) |=> !conv_req);
  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  // R8
  battery_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && !bat_en) |=> !conv_req);
endmodule

// File: rtl/tcomp_trim_sel.sv
module tcomp_trim_sel
  import tcomp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sense_en,
  input  logic                     corr_load,
  input  logic [ATRIM_W-1:0]       init_atrim,
  input  logic [DTRIM_W-1:0]       init_dtrim,
  input  logic [ATRIM_W-1:0]       conv_atrim,
  input  logic [DTRIM_W-1:0]       conv_dtrim,
  output logic [ATRIM_W-1:0]       osc_atrim,
  output logic [DTRIM_W-1:0]       osc_dtrim,
  output logic signed [OFFS_W-1:0] atrim_offset
);
  logic [ATRIM_W-1:0] corr_atrim;
  logic [DTRIM_W-1:0] corr_dtrim;

  // Shadow tracks the initial values while idle, so enabling needs no copy cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_atrim <= '0;
      corr_dtrim <= '0;
    end else if (!sense_en) begin
      corr_atrim <= init_atrim;
      corr_dtrim <= init_dtrim;
    end else if (corr_load) begin
      corr_atrim <= conv_atrim;
      corr_dtrim <= conv_dtrim;
    end
  end

  assign osc_atrim    = sense_en ? corr_atrim : init_atrim;
  assign osc_dtrim    = sense_en ? corr_dtrim : init_dtrim;
  assign atrim_offset = decode_atrim(osc_atrim);

  // R11
  corr_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_load |=> (!sense_en || osc_dtrim == $past(conv_dtrim)));
  // R2
  enabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_en && $past(sense_en) && !$past(corr_load)) |-> $stable(osc_atrim));
endmodule

// File: rtl/tcomp_seq_ctrl.sv
module tcomp_seq_ctrl
  import tcomp_pkg::*;
#(
  parameter int CNT_FAST = 60,
  parameter int CNT_SLOW = 600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        tick_1hz,
  input  logic        on_battery,
  input  logic        batt_low,
  output logic        conv_req,
  input  logic        conv_done,
  input  logic [5:0]  conv_atrim,
  input  logic [7:0]  conv_dtrim,
  output logic [5:0]  osc_atrim,
  output logic [7:0]  osc_dtrim,
  output logic [6:0]  atrim_offset
);
  logic [ATRIM_W-1:0] init_atrim;
  logic [DTRIM_W-1:0] init_dtrim;
  logic               sense_en, bat_en, rate_sel, corr_load;
  logic signed [OFFS_W-1:0] offs;

  tcomp_regfile u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .batt_low,
    .reg_rdata, .init_atrim, .init_dtrim, .sense_en, .bat_en, .rate_sel
  );

  tcomp_scheduler #(.CNT_FAST(CNT_FAST), .CNT_SLOW(CNT_SLOW)) u_sched (
    .clk, .rst_n, .tick_1hz, .sense_en, .bat_en, .rate_sel, .on_battery,
    .conv_done, .conv_req, .corr_load
  );

  tcomp_trim_sel u_trim (
    .clk, .rst_n, .sense_en, .corr_load, .init_atrim, .init_dtrim,
    .conv_atrim, .conv_dtrim, .osc_atrim, .osc_dtrim, .atrim_offset(offs)
  );

  assign atrim_offset = offs;
endmodule

// File: tb/tb_tcomp_seq_ctrl.sv
`timescale 1ns/1ps
module tb_tcomp_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tick_1hz = 1'b0, on_battery = 1'b0, batt_low = 1'b0;
  logic conv_req, conv_done = 1'b0;
  logic [5:0] conv_atrim = '0;
  logic [7:0] conv_dtrim = '0;
  logic [5:0] osc_atrim;
  logic [7:0] osc_dtrim;
  logic [6:0] atrim_offset;

  always #2.5 clk = ~clk;

  tcomp_seq_ctrl dut (.*);

  int checks = 0, errors = 0;
  int tick_total = 0;
  bit tick_on = 0, auto_done = 1;
  int resp_dly = 3;
  int req_ticks[$];
  int next_a = 40, next_d = 7;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_ia, m_id, m_al, m_beta, m_cnt, m_ca, m_cd;
  bit m_en, m_bat, m_rate, m_en_d, m_busy, m_req;
  always @(posedge clk) begin
    bit rise, act, hit, issue, acc;
    int intv;
    if (!rst_n) begin
      m_ia = 0; m_id = 0; m_al = 0; m_beta = 0; m_cnt = 0; m_ca = 0; m_cd = 0;
      m_en = 0; m_bat = 0; m_rate = 0; m_en_d = 0; m_busy = 0; m_req = 0;
    end else begin
      rise = m_en && !m_en_d;
      act = m_en && (!on_battery || m_bat);
      intv = (on_battery && !m_rate) ? 600 : 60;
      hit = act && tick_1hz && (m_cnt >= intv - 1);
      issue = act && !m_busy && (rise || hit);
      acc = m_busy && conv_done;
      if (!m_en) begin m_ca = m_ia; m_cd = m_id; end
      else if (acc) begin m_ca = conv_atrim; m_cd = conv_dtrim; end
      if (rise || !act) m_cnt = 0;
      else if (tick_1hz) m_cnt = hit ? 0 : m_cnt + 1;
      if (issue) m_busy = 1; else if (acc) m_busy = 0;
      m_req = issue;
      m_en_d = m_en;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (!m_en) m_ia = reg_wdata % 64;
          3'd1: if (!m_en) m_id = reg_wdata;
          3'd2: if (!m_en) m_al = reg_wdata % 128;
          3'd3: begin
            if (!m_en) m_beta = reg_wdata % 16;
            m_en = reg_wdata[7]; m_bat = reg_wdata[6]; m_rate = reg_wdata[5];
          end
          default: ;
        endcase
      end
      if (batt_low) m_bat = 0;
    end
  end

  function automatic int model_rdata(int a);
    case (a)
      0: return m_ia;
      1: return m_id;
      2: return m_al;
      3: return m_en * 128 + m_bat * 64 + m_rate * 32 + m_beta;
      default: return 0;
    endcase
  endfunction

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int ea;
      ea = m_en ? m_ca : m_ia;
      chk("R7 conv_req", conv_req, m_req);
      chk("R2 osc_atrim", osc_atrim, ea);
      chk("R2 osc_dtrim", osc_dtrim, m_en ? m_cd : m_id);
      chk("R12 atrim_offset", $signed(atrim_offset), 32 - ea);
      chk("R4 reg_rdata", reg_rdata, model_rdata(reg_addr));
      if (conv_req) req_ticks.push_back(tick_total);
    end
  end

  // Tick source
  initial forever begin
    repeat (3) @(negedge clk);
    if (tick_on) begin tick_1hz = 1'b1; tick_total++; end
    @(negedge clk);
    tick_1hz = 1'b0;
  end

  // Converter responder
  initial forever begin
    @(negedge clk);
    #2;
    if (conv_req && auto_done) begin
      repeat (resp_dly) @(negedge clk);
      conv_atrim = 6'(next_a); conv_dtrim = 8'(next_d); conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      next_a = (next_a + 5) % 64; next_d = (next_d + 11) % 256;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = tick_total + n;
    while (tick_total < target) @(negedge clk);
  endtask

  task automatic wait_reqs(input int n);
    int target;
    target = req_ticks.size() + n;
    while (req_ticks.size() < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 conv_req", conv_req, 0);
    chk("R1 osc_atrim", osc_atrim, 0);
    for (int a = 0; a < 4; a++) rd(3'(a), 0, "R1 reset readback");

    // R5 field widths
    wr(3'd2, 8'hA3);
    rd(3'd2, 35, "R5 alpha bit7 reads 0");
    wr(3'd0, 8'hCC);
    rd(3'd0, 12, "R5 atrim upper bits read 0");
    rd(3'd6, 0, "R5 unmapped address");
    // R4 control layout
    wr(3'd3, 8'h35);
    rd(3'd3, 8'h25, "R4 control readback");

    // R12 decode corners
    wr(3'd0, 8'd31); rd(3'd0, 31, "R12 setup"); chk("R12 code31", $signed(atrim_offset), 1);
    wr(3'd0, 8'd32); #1; chk("R12 code32", $signed(atrim_offset), 0);
    wr(3'd0, 8'd63); #1; chk("R12 code63", $signed(atrim_offset), -31);
    wr(3'd0, 8'd0);  #1; chk("R12 code0", $signed(atrim_offset), 32);
    wr(3'd0, 8'd12); #1; chk("R12 code12", $signed(atrim_offset), 20);
    wr(3'd1, 8'hA5);

    // R6 enable: immediate request, initial values until done
    tick_on = 1;
    n0 = req_ticks.size();
    wr(3'd3, 8'h85);
    #1;
    chk("R2 init before done", osc_atrim, 12);
    @(negedge clk); #2;
    chk("R6 request after enable", req_ticks.size(), n0 + 1);
    repeat (6) @(negedge clk);
    #1;
    chk("R11 corrected atrim", osc_atrim, 40);
    chk("R11 corrected dtrim", osc_dtrim, 7);

    // R3 lock
    wr(3'd2, 8'd10); wr(3'd0, 8'd1); wr(3'd1, 8'd1); wr(3'd3, 8'hAF);
    rd(3'd2, 35, "R3 alpha locked");
    rd(3'd0, 12, "R3 atrim locked");
    rd(3'd1, 8'hA5, "R3 dtrim locked");
    rd(3'd3, 8'hA5, "R3 beta locked, rate writable");

    // R7 main power ignores rate bit
    wait_reqs(2);
    chk("R7 main-power interval", req_ticks[$] - req_ticks[$-1], 60);

    // R8 battery gating and intervals
    on_battery = 1'b1;
    wr(3'd3, 8'h85);
    repeat (10) @(negedge clk);
    n0 = req_ticks.size();
    wait_ticks(650);
    chk("R8 no requests with battery enable 0", req_ticks.size(), n0);
    wr(3'd3, 8'hC5);
    wait_reqs(2);
    chk("R8 slow battery interval", req_ticks[$] - req_ticks[$-1], 600);
    wr(3'd3, 8'hE5);
    wait_reqs(2);
    chk("R8 fast battery interval", req_ticks[$] - req_ticks[$-1], 60);

    // R9 low battery
    batt_low = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd3, 8'hA5, "R9 battery enable cleared");
    wr(3'd3, 8'hE5);
    rd(3'd3, 8'hA5, "R9 battery enable write blocked");
    repeat (10) @(negedge clk);
    n0 = req_ticks.size();
    wait_ticks(100);
    chk("R9 no requests under low battery", req_ticks.size(), n0);
    batt_low = 1'b0;
    on_battery = 1'b0;

    // R10 outstanding request blocks further ones
    wr(3'd3, 8'h05);
    repeat (20) @(negedge clk);
    auto_done = 0;
    n0 = req_ticks.size();
    wr(3'd3, 8'h85);
    wait_ticks(130);
    chk("R10 intervals skipped while busy", req_ticks.size(), n0 + 1);
    @(negedge clk);
    conv_atrim = 6'd50; conv_dtrim = 8'd99; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    #1;
    chk("R11 late done accepted", osc_atrim, 50);

    // R11 result discarded after disable
    wr(3'd3, 8'h05);
    repeat (5) @(negedge clk);
    auto_done = 1; resp_dly = 30;
    wr(3'd3, 8'h85);
    repeat (8) @(negedge clk);
    wr(3'd3, 8'h05);
    repeat (40) @(negedge clk);
    #1;
    chk("R11 discarded atrim", osc_atrim, 12);
    chk("R11 discarded dtrim", osc_dtrim, 8'hA5);
    tick_on = 0;
    repeat (10) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule